// File: doc/BRIEF.md
# Interlocked Read Handshake over a Shared Address/Data Bus

This block joins a read requester and a memory responder over a bus that carries no timing reference between the two parties. One set of shared lines carries first the address and then the returned word. Three control wires are used: a read request from the requester, a data-ready strobe from the memory, and an acknowledge that each party drives in turn. Every edge on these wires answers an edge from the other party. Because of this, neither side assumes how fast the other is, and each side passes the other party's control wires through a flop synchronizer before acting on them.

The user logic issues a read command with an address while the block is idle. The block then runs the full exchange. It ends with a one-cycle done pulse and the captured word on the read-data output. The memory side serves the read from an internal word array that takes a fixed, computed content at reset. The control wires and the resolved value of the shared lines are brought out as ports so that the exchange can be observed.

Top module: `arh_read_link`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, read_req_o, data_rdy_o, ack_o, done_o and busy_o are 0 and bus_o is 0.
- R2: A command (cmd_valid_i high) sampled while busy_o is low is accepted at that clock edge. From the next cycle read_req_o and busy_o are 1, and bus_o carries cmd_addr_i zero-extended to DW bits.
- R3: While busy_o is high, cmd_valid_i and cmd_addr_i are ignored. No second exchange starts and the address on the bus is unchanged.
- R4: read_req_o and data_rdy_o are never high in the same cycle.
- R5: The two parties never drive the shared lines in the same cycle. While read_req_o is high, bus_o equals the requested address. While data_rdy_o is high, bus_o equals the word being returned.
- R6: Control edges occur strictly in this order, one per cycle at most: request rises, ack rises, request falls, ack falls, data-ready rises, ack rises, data-ready falls, ack falls, then done pulses.
- R7: The word returned for address a is ((a * 257) mod 2^DW) XOR FILL, with FILL = 16'hA5C3 by default.
- R8: done_o is high for exactly one cycle. It comes after the final ack fall has been seen, in the same cycle as busy_o returns to 0. rd_data_o holds the returned word until the next done pulse.
- R9: Each party reacts to an edge from the other only through a SYNC_STAGES-flop synchronizer. The memory's ack rises no earlier than SYNC_STAGES+1 cycles after the request rises (3 cycles by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Read command strobe, taken when idle |
| cmd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Word returned by the last completed read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Exchange in progress |
| read_req_o | output | 1 | Request control wire |
| data_rdy_o | output | 1 | Data-ready control wire |
| ack_o | output | 1 | Shared acknowledge wire (OR of both parties) |
| bus_o | output | DW | Resolved value of the shared address/data lines |

## Verification
The hardest situation to reach is a command that arrives right at the done pulse. At that moment the memory is still waiting for the requester's acknowledge to fall through its synchronizer, so a stale high acknowledge could be read as a fresh answer. The bench issues the next command in the same cycle that it sees done, both in directed back-to-back pairs and in part of the random traffic. A port-level monitor checks every control edge against the nine-step order and the bus contents in each phase. A separate directed case holds the command strobe high with a different address while an exchange is in flight.

// File: rtl/arh_pkg.sv
package arh_pkg;
  typedef enum logic [2:0] {
    RQ_IDLE, RQ_ADDR, RQ_REL, RQ_WDATA, RQ_ACK, RQ_FIN
  } rq_state_e;

  typedef enum logic [2:0] {
    MS_IDLE, MS_ACK, MS_PREP, MS_DATA, MS_DONE
  } ms_state_e;
endpackage

// File: rtl/arh_sync.sv
module arh_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/arh_requester.sv
module arh_requester import arh_pkg::*; #(
  parameter int AW          = 6,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic          ack_i,
  input  logic          rdy_i,
  input  logic [DW-1:0] bus_i,
  output logic          read_req_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          busy_o
);
  logic [1:0]    ctl_s;
  logic          ack_s, rdy_s;
  rq_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  arh_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_i, rdy_i}),
    .q_o   (ctl_s)
  );
  assign ack_s = ctl_s[1];
  assign rdy_s = ctl_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RQ_IDLE;
      addr_q     <= '0;
      data_q     <= '0;
      read_req_o <= 1'b0;
      ack_o      <= 1'b0;
      oe_o       <= 1'b0;
      drv_o      <= '0;
      rd_data_o  <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        RQ_IDLE: if (cmd_valid_i) begin
          addr_q     <= cmd_addr_i;
          drv_o      <= DW'(cmd_addr_i);
          oe_o       <= 1'b1;
          read_req_o <= 1'b1;
          st_q       <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) begin
          read_req_o <= 1'b0;
          oe_o       <= 1'b0;
          drv_o      <= '0;
          st_q       <= RQ_REL;
        end
        RQ_REL: if (!ack_s) st_q <= RQ_WDATA;
        RQ_WDATA: if (rdy_s) begin
          data_q <= bus_i;
          ack_o  <= 1'b1;
          st_q   <= RQ_ACK;
        end
        RQ_ACK: if (!rdy_s) begin
          ack_o <= 1'b0;
          st_q  <= RQ_FIN;
        end
        // own ack must read low through the synchronizer before reuse
        RQ_FIN: if (!ack_s) begin
          rd_data_o <= data_q;
          done_o    <= 1'b1;
          st_q      <= RQ_IDLE;
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != RQ_IDLE);

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i) |=> (read_req_o && oe_o && busy_o));

  p_busy_ignores_cmd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> $stable(addr_q));

  p_req_drop_on_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(read_req_o) |-> $past(ack_s));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/arh_responder.sv
module arh_responder import arh_pkg::*; #(
  parameter int          AW          = 6,
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned FILL        = 'hA5C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  input  logic [AW-1:0] bus_i,
  output logic          data_rdy_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drv_o
);
  localparam int DEPTH = 1 << AW;

  logic [1:0]    ctl_s;
  logic          ack_s, req_s;
  ms_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] mem_q [DEPTH];

  function automatic logic [DW-1:0] cell_init(int unsigned a);
    return DW'(a * 257) ^ DW'(FILL);
  endfunction

  arh_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_i, req_i}),
    .q_o   (ctl_s)
  );
  assign ack_s = ctl_s[1];
  assign req_s = ctl_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= cell_init(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= MS_IDLE;
      addr_q     <= '0;
      data_rdy_o <= 1'b0;
      ack_o      <= 1'b0;
      oe_o       <= 1'b0;
      drv_o      <= '0;
    end else begin
      unique case (st_q)
        MS_IDLE: if (req_s && !ack_s) begin
          addr_q <= bus_i;
          ack_o  <= 1'b1;
          st_q   <= MS_ACK;
        end
        MS_ACK: if (!req_s) begin
          ack_o <= 1'b0;
          st_q  <= MS_PREP;
        end
        MS_PREP: if (!ack_s) begin
          drv_o      <= mem_q[addr_q];
          oe_o       <= 1'b1;
          data_rdy_o <= 1'b1;
          st_q       <= MS_DATA;
        end
        MS_DATA: if (ack_s) begin
          data_rdy_o <= 1'b0;
          oe_o       <= 1'b0;
          drv_o      <= '0;
          st_q       <= MS_DONE;
        end
        MS_DONE: if (!ack_s) st_q <= MS_IDLE;
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  p_rdy_after_req_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_rdy_o) |-> !req_s);

  p_rdy_owns_bus_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o |-> oe_o);

  p_ack_needs_sync_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(req_s));
endmodule

// File: rtl/arh_read_link.sv
module arh_read_link #(
  parameter int          AW          = 6,
  parameter int          DW          = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned FILL        = 'hA5C3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [AW-1:0] cmd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          read_req_o,
  output logic          data_rdy_o,
  output logic          ack_o,
  output logic [DW-1:0] bus_o
);
  logic          rq_ack, rq_oe, ms_ack, ms_oe;
  logic [DW-1:0] rq_drv, ms_drv;

  // shared lines: per-party drive with enable, resolved here
  assign bus_o = rq_oe ? rq_drv : (ms_oe ? ms_drv : '0);
  assign ack_o = rq_ack | ms_ack;

  arh_requester #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_rq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_addr_i (cmd_addr_i),
    .ack_i      (ack_o),
    .rdy_i      (data_rdy_o),
    .bus_i      (bus_o),
    .read_req_o (read_req_o),
    .ack_o      (rq_ack),
    .oe_o       (rq_oe),
    .drv_o      (rq_drv),
    .rd_data_o  (rd_data_o),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  arh_responder #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES), .FILL(FILL)) u_ms (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (read_req_o),
    .ack_i     (ack_o),
    .bus_i     (bus_o[AW-1:0]),
    .data_rdy_o(data_rdy_o),
    .ack_o     (ms_ack),
    .oe_o      (ms_oe),
    .drv_o     (ms_drv)
  );

  p_no_bus_clash_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rq_oe && ms_oe));

  p_req_rdy_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(read_req_o && data_rdy_o));

  p_one_ack_driver_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rq_ack && ms_ack));
endmodule

// File: tb/arh_read_link_tb.sv
module arh_read_link_tb;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] rd_data, bus;
  logic          done, busy, rreq, drdy, ack;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [AW-1:0] cur_addr = '0;

  always #5 clk = ~clk;

  arh_read_link #(.AW(AW), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr),
    .rd_data_o(rd_data), .done_o(done), .busy_o(busy), .read_req_o(rreq),
    .data_rdy_o(drdy), .ack_o(ack), .bus_o(bus)
  );

  function automatic logic [DW-1:0] exp_word(int unsigned a);
    return DW'(a * 257) ^ 16'hA5C3;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // port monitor: edge order, bus contents, sync latency
  int   phase = 0;
  int   rise_cyc = 0;
  logic p_rreq = 0, p_drdy = 0, p_ack = 0, p_done = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      int nev;
      int code;
      nev  = 0;
      code = 99;
      if (rreq && !p_rreq) begin nev++; code = 0; rise_cyc = cyc; end
      if (!rreq && p_rreq) begin nev++; code = 2; end
      if (drdy && !p_drdy) begin nev++; code = 4; end
      if (!drdy && p_drdy) begin nev++; code = 6; end
      if (ack && !p_ack) begin
        nev++;
        code = (phase == 1 || phase == 5) ? phase : 98;
        if (phase == 1) check(cyc - rise_cyc >= 3, "R9 sync latency", cyc - rise_cyc, 3);
      end
      if (!ack && p_ack) begin nev++; code = (phase == 3 || phase == 7) ? phase : 97; end
      if (done && !p_done) begin nev++; code = 8; end
      if (nev > 1) check(1'b0, "R6 one edge per cycle", nev, 1);
      else if (nev == 1) begin
        check(code == phase, "R6 edge order", code, phase);
        phase = (phase == 8) ? 0 : phase + 1;
      end
      if (done && p_done) check(1'b0, "R8 done one cycle", 2, 1);
      if (rreq && drdy) check(1'b0, "R4 req/rdy exclusive", 1, 0);
      if (rreq) check(bus == DW'(cur_addr), "R5 bus carries address", bus, DW'(cur_addr));
      if (drdy) check(bus == exp_word(cur_addr), "R5 bus carries data", bus, exp_word(cur_addr));
    end
    p_rreq = rreq; p_drdy = drdy; p_ack = ack; p_done = done;
  end

  // issue at a negedge, return at the negedge where done is seen
  task automatic do_read(input logic [AW-1:0] a, input int spam);
    int t;
    cur_addr  = a;
    cmd_valid = 1'b1;
    cmd_addr  = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy && rreq, "R2 accept", {busy, rreq}, 2'b11);
    check(bus == DW'(a), "R2 address on bus", bus, DW'(a));
    for (int i = 0; i < spam; i++) begin
      cmd_valid = 1'b1;
      cmd_addr  = a ^ 6'h15;
      @(negedge clk);
      check(rreq == 1'b0 || bus == DW'(a), "R3 address unchanged", bus, DW'(a));
    end
    cmd_valid = 1'b0;
    t = 0;
    while (!done && t < 400) begin @(negedge clk); t++; end
    check(done, "R8 done seen", done, 1);
    check(rd_data == exp_word(a), "R7 read word", rd_data, exp_word(a));
    check(!busy, "R8 idle with done", busy, 0);
  endtask

  task automatic idle_hold(input int n, input logic [DW-1:0] held, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rreq || done) check(1'b0, req, {rreq, done}, 0);
    end
    check(rd_data == held, "R8 data held", rd_data, held);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    check({rreq, drdy, ack, done, busy} == 0 && bus == 0, "R1 in reset",
          {rreq, drdy, ack, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rreq, drdy, ack, done, busy} == 0 && bus == 0, "R1 after reset",
          {rreq, drdy, ack, done, busy}, 0);

    do_read(6'd0, 0);
    idle_hold(5, exp_word(0), "R8 quiet after done");
    do_read(6'd63, 0);
    idle_hold(3, exp_word(63), "R8 quiet after done");
    do_read(6'd5, 0);
    do_read(6'd6, 0);
    do_read(6'd62, 0);
    idle_hold(4, exp_word(62), "R8 quiet after done");

    // strobe held during an exchange must not start another (R3)
    do_read(6'd17, 6);
    idle_hold(20, exp_word(17), "R3 no extra exchange");

    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      int gap;
      a   = AW'($urandom_range(0, (1 << AW) - 1));
      gap = $urandom_range(0, 3);
      do_read(a, ($urandom_range(0, 3) == 0) ? 3 : 0);
      if (gap != 0) idle_hold(gap, exp_word(a), "R8 quiet after done");
    end

    repeat (10) @(negedge clk);
    check(phase == 0, "R6 exchange complete", phase, 0);
    check(!busy && !rreq && !drdy && !ack, "R1 back to idle", {busy, rreq, drdy, ack}, 0);
    finish_run();
  end
endmodule